// File: doc/BRIEF.md
# Bridge-Sensor Converter Readout Controller

This block sits on the host side of a read-only, pin-configured sigma-delta converter that serves bridge sensors such as load cells and pressure cells. It talks to the converter over two wires. It drives a serial clock out, and it receives a single line that first signals data-ready by going low and then carries the data. The controller waits for the ready level and generates the serial clock from the system clock. It captures a 28-bit frame, made of a 20-bit conversion followed by an 8-bit status byte. It then delivers the conversion either in its native offset-binary code or as two's complement, together with a one-cycle valid strobe.

The controller also drives the converter's configuration pins: the power-down/reset pin, the amplifier-gain pin and the filter (update-rate) pin. Any change on the gain or filter pin, and any exit from power-down, starts a settling window. Frames that complete inside that window are read to keep the link clear, but they are dropped silently. The status byte is compared with a software-chosen pattern under a mask, so that a corrupted transfer is flagged. A watchdog on the ready line reports a converter that has stopped producing data.

Top module: `bridge_adc_reader`

## Requirements
- R1: `sclk` is high whenever no frame is being read, including the whole time `pd_rst_n` is low.
- R2: A read starts only after `dout_rdy` has been seen high and then low. Each read produces exactly 28 falling edges on `sclk`, and no falling edge occurs while `dout_rdy` stays high.
- R3: Every low phase and every high phase of `sclk` within a frame lasts at least `HALF_CYC` system clocks.
- R4: Data is sampled as `sclk` rises, most significant bit first. Frame bits 27..8 form the conversion and bits 7..0 form the status byte, which appears on `status_byte` once a frame outside the settling window completes.
- R5: With `signed_out`=0, `result` is the raw offset-binary code. With `signed_out`=1, bit 19 of that code is inverted, which gives two's complement.
- R6: A frame whose status differs from `status_expect` in any bit set in `status_mask` raises `frame_error` and no `result_valid`, and it leaves `result` unchanged.
- R7: `result_valid` and `frame_error` are single-cycle pulses and never occur together. `result` holds its value between valid pulses.
- R8: `pd_rst_n` is low while `run_en` is low. Once low, it stays low for at least `RESET_LOW_CYC` clocks before it is released.
- R9: `pin_gain` and `pin_filter` follow `cfg_gain_hi` and `cfg_slow` one clock later. Each change starts a settling window of `SETTLE_FAST_CYC` clocks (filter pin 0, faster rate) or `SETTLE_SLOW_CYC` clocks (filter pin 1, slower rate). A frame that completes inside the window produces neither pulse.
- R10: Releasing `pd_rst_n` starts a settling window that is `WAKE_CYC` clocks longer than the window of the current mode.
- R11: `ready_timeout` rises once `dout_rdy` has stayed high, outside any settling window, for 2×`UPD_FAST_CYC` clocks (filter pin 0) or 2×`UPD_SLOW_CYC` clocks (filter pin 1). It clears when a read starts or when a settling window begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = converter powered and read; 0 = hold it in power-down/reset |
| cfg_gain_hi | input | 1 | Requested amplifier-gain pin level |
| cfg_slow | input | 1 | Requested filter pin level (1 = slower update rate) |
| signed_out | input | 1 | 1 = deliver result as two's complement |
| status_expect | input | 8 | Expected status pattern |
| status_mask | input | 8 | Status bits that take part in the comparison |
| dout_rdy | input | 1 | Shared ready / serial data line from the converter |
| sclk | output | 1 | Serial clock to the converter, idle high |
| pd_rst_n | output | 1 | Power-down/reset pin, active low |
| pin_gain | output | 1 | Gain pin |
| pin_filter | output | 1 | Filter pin |
| result | output | 20 | Last accepted conversion |
| status_byte | output | 8 | Status byte of the last frame outside settling |
| result_valid | output | 1 | One-cycle strobe for a new accepted conversion |
| frame_error | output | 1 | One-cycle strobe for a status mismatch |
| ready_timeout | output | 1 | Ready line has been missing for too long |

## Verification
The bench goes after the codes at the ends and the middle of the range, in both output formats. A mishandled MSB inversion, or a bit shifted by one sclk edge, shows up there as a wrong value. Settling windows are probed with frames that finish just inside them. A controller that ignored the filter-dependent length, or the extra wake-up time, would emit a valid strobe too early. The masked status compare is exercised with patterns that differ only in masked or only in unmasked bits. A wrong mask would drop good frames or pass bad ones, and the bench also confirms that a rejected frame does not disturb `result`. The timeout is sampled just short of its limit and just past it in both modes. The same windows confirm that `sclk` never toggles while the ready line stays high, and they show whether the reset pulse is shortened when `run_en` is only briefly removed.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int DATA_BITS  = 20;
  localparam int STAT_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + STAT_BITS;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAIT_HIGH,
    ST_ARMED,
    ST_READ
  } rd_state_e;
endpackage

// File: rtl/bar_frame_shifter.sv
module bar_frame_shifter #(
  parameter int HALF_CYC = 10,
  parameter int NBITS    = 28
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  input  logic             abort,
  input  logic             sdi,
  output logic             sclk,
  output logic             done,
  output logic [NBITS-1:0] frame
);
  localparam int DIV_W = $clog2(HALF_CYC + 1);
  localparam int BIT_W = $clog2(NBITS + 1);
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(NBITS - 1);

  logic             busy_q, busy_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [NBITS-1:0] frame_q, frame_d;

  always_comb begin
    busy_d  = busy_q;
    sclk_d  = sclk_q;
    div_d   = div_q;
    bit_d   = bit_q;
    frame_d = frame_q;
    done_d  = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      sclk_d = 1'b1;
    end else if (!busy_q) begin
      sclk_d = 1'b1;
      if (start) begin
        busy_d = 1'b1;
        sclk_d = 1'b0;
        div_d  = HALF_LAST;
        bit_d  = '0;
      end
    end else if (div_q != '0) begin
      div_d = div_q - 1'b1;
    end else if (!sclk_q) begin
      // rising edge: capture the bit presented on the previous falling edge
      sclk_d  = 1'b1;
      frame_d = {frame_q[NBITS-2:0], sdi};
      div_d   = HALF_LAST;
    end else if (bit_q == BIT_LAST) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      sclk_d = 1'b0;
      bit_d  = bit_q + 1'b1;
      div_d  = HALF_LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b1;
      done_q  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      frame_q <= '0;
    end else begin
      busy_q  <= busy_d;
      sclk_q  <= sclk_d;
      done_q  <= done_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
      frame_q <= frame_d;
    end
  end

  assign sclk  = sclk_q;
  assign done  = done_q;
  assign frame = frame_q;
endmodule

// File: rtl/bar_settle_timer.sv
module bar_settle_timer #(
  parameter int SETTLE_FAST_CYC = 1000,
  parameter int SETTLE_SLOW_CYC = 2500,
  parameter int WAKE_CYC        = 300,
  parameter int UPD_FAST_CYC    = 1500,
  parameter int UPD_SLOW_CYC    = 2500
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic restart,
  input  logic wake,
  input  logic slow,
  input  logic wait_en,
  output logic settling,
  output logic timed_out
);
  localparam int SET_W = $clog2(SETTLE_SLOW_CYC + WAKE_CYC + 1);
  localparam int TO_W  = $clog2(2 * UPD_SLOW_CYC + 1);
  localparam logic [SET_W-1:0] L_FAST = SET_W'(SETTLE_FAST_CYC);
  localparam logic [SET_W-1:0] L_SLOW = SET_W'(SETTLE_SLOW_CYC);
  localparam logic [SET_W-1:0] L_WAKE = SET_W'(WAKE_CYC);
  localparam logic [TO_W-1:0]  T_FAST = TO_W'(2 * UPD_FAST_CYC);
  localparam logic [TO_W-1:0]  T_SLOW = TO_W'(2 * UPD_SLOW_CYC);

  logic [SET_W-1:0] set_q, set_d;
  logic [TO_W-1:0]  to_q, to_d;
  logic [TO_W-1:0]  to_lim;

  assign settling = (set_q != '0);
  assign to_lim   = slow ? T_SLOW : T_FAST;

  always_comb begin
    set_d = set_q;
    if (restart)       set_d = (slow ? L_SLOW : L_FAST) + (wake ? L_WAKE : '0);
    else if (settling) set_d = set_q - 1'b1;

    to_d = '0;
    if (wait_en && !settling && !restart) to_d = (to_q == T_SLOW) ? to_q : to_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
      to_q  <= '0;
    end else begin
      set_q <= set_d;
      to_q  <= to_d;
    end
  end

  assign timed_out = (to_q >= to_lim);
endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader #(
  parameter int HALF_CYC        = 10,
  parameter int RESET_LOW_CYC   = 10,
  parameter int SETTLE_FAST_CYC = 12_000_000,
  parameter int SETTLE_SLOW_CYC = 30_000_000,
  parameter int WAKE_CYC        = 100_000,
  parameter int UPD_FAST_CYC    = 6_000_000,
  parameter int UPD_SLOW_CYC    = 10_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_en,
  input  logic        cfg_gain_hi,
  input  logic        cfg_slow,
  input  logic        signed_out,
  input  logic [7:0]  status_expect,
  input  logic [7:0]  status_mask,
  input  logic        dout_rdy,
  output logic        sclk,
  output logic        pd_rst_n,
  output logic        pin_gain,
  output logic        pin_filter,
  output logic [19:0] result,
  output logic [7:0]  status_byte,
  output logic        result_valid,
  output logic        frame_error,
  output logic        ready_timeout
);
  import bar_pkg::*;

  localparam int RC_W = $clog2(RESET_LOW_CYC + 1);
  localparam logic [RC_W-1:0] RST_LAST = RC_W'(RESET_LOW_CYC - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // ready/data line resynchronised, idles high
  logic [1:0] rdy_sync_q;
  logic       rdy_s;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdy_sync_q <= 2'b11;
    else         rdy_sync_q <= {rdy_sync_q[0], dout_rdy};
  end
  assign rdy_s = rdy_sync_q[1];

  rd_state_e            state_q, state_d;
  logic [RC_W-1:0]      rcnt_q, rcnt_d;
  logic                 gain_q, filt_q;
  logic [DATA_BITS-1:0] res_q, res_d;
  logic [STAT_BITS-1:0] stat_q, stat_d;
  logic                 val_q, val_d, err_q, err_d;

  logic                  sh_start, sh_abort, sh_done;
  logic [FRAME_BITS-1:0] sh_frame;
  logic                  leave_off, pin_change, settle_busy, wait_to;
  logic                  mismatch;
  logic [DATA_BITS-1:0]  code;

  bar_frame_shifter #(.HALF_CYC(HALF_CYC), .NBITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_ni(rst_ni), .start(sh_start), .abort(sh_abort),
    .sdi(rdy_s), .sclk(sclk), .done(sh_done), .frame(sh_frame)
  );

  bar_settle_timer #(
    .SETTLE_FAST_CYC(SETTLE_FAST_CYC), .SETTLE_SLOW_CYC(SETTLE_SLOW_CYC),
    .WAKE_CYC(WAKE_CYC), .UPD_FAST_CYC(UPD_FAST_CYC), .UPD_SLOW_CYC(UPD_SLOW_CYC)
  ) u_timer (
    .clk(clk), .rst_ni(rst_ni), .restart(leave_off || pin_change),
    .wake(leave_off), .slow(cfg_slow), .wait_en(state_q == ST_ARMED),
    .settling(settle_busy), .timed_out(wait_to)
  );

  assign pin_change = (cfg_gain_hi != gain_q) || (cfg_slow != filt_q);
  assign mismatch   = |((sh_frame[STAT_BITS-1:0] ^ status_expect) & status_mask);
  assign code       = sh_frame[FRAME_BITS-1:STAT_BITS] ^
                      {signed_out, {(DATA_BITS-1){1'b0}}};

  always_comb begin
    state_d   = state_q;
    rcnt_d    = rcnt_q;
    leave_off = 1'b0;
    sh_start  = 1'b0;
    sh_abort  = 1'b0;
    if (state_q == ST_OFF) begin
      if (rcnt_q != RST_LAST) rcnt_d = rcnt_q + 1'b1;
      if (run_en && rcnt_q == RST_LAST) begin
        leave_off = 1'b1;
        state_d   = ST_WAIT_HIGH;
      end
    end else if (!run_en) begin
      sh_abort = 1'b1;
      rcnt_d   = '0;
      state_d  = ST_OFF;
    end else begin
      unique case (state_q)
        ST_WAIT_HIGH: if (rdy_s) state_d = ST_ARMED;
        ST_ARMED: if (!rdy_s) begin
          sh_start = 1'b1;
          state_d  = ST_READ;
        end
        ST_READ: if (sh_done) state_d = ST_WAIT_HIGH;
        default: state_d = ST_OFF;
      endcase
    end

    val_d  = sh_done && !settle_busy && !mismatch;
    err_d  = sh_done && !settle_busy && mismatch;
    res_d  = val_d ? code : res_q;
    stat_d = (sh_done && !settle_busy) ? sh_frame[STAT_BITS-1:0] : stat_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rcnt_q  <= '0;
      gain_q  <= 1'b0;
      filt_q  <= 1'b0;
      res_q   <= '0;
      stat_q  <= '0;
      val_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rcnt_q  <= rcnt_d;
      gain_q  <= cfg_gain_hi;
      filt_q  <= cfg_slow;
      res_q   <= res_d;
      stat_q  <= stat_d;
      val_q   <= val_d;
      err_q   <= err_d;
    end
  end

  assign pd_rst_n      = (state_q != ST_OFF);
  assign pin_gain      = gain_q;
  assign pin_filter    = filt_q;
  assign result        = res_q;
  assign status_byte   = stat_q;
  assign result_valid  = val_q;
  assign frame_error   = err_q;
  assign ready_timeout = wait_to;
endmodule

// File: rtl/bar_reader_checks.sv
module bar_reader_checks #(
  parameter int HALF_CYC      = 10,
  parameter int RESET_LOW_CYC = 10
) (
  input logic clk,
  input logic rst_ni,
  input logic run_en,
  input logic sclk,
  input logic pd_rst_n,
  input logic pin_gain,
  input logic pin_filter,
  input logic result_valid,
  input logic frame_error,
  input logic settling
);
  logic        sclk_prev, pd_prev;
  logic [15:0] lvl_cnt, low_cnt;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev <= 1'b1;
      pd_prev   <= 1'b0;
      lvl_cnt   <= 16'hFFFF;
      low_cnt   <= 16'd0;
    end else begin
      sclk_prev <= sclk;
      pd_prev   <= pd_rst_n;
      if (sclk != sclk_prev)    lvl_cnt <= 16'd1;
      else if (lvl_cnt != '1)   lvl_cnt <= lvl_cnt + 1'b1;
      if (pd_rst_n)             low_cnt <= 16'd0;
      else if (low_cnt != '1)   low_cnt <= low_cnt + 1'b1;
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !pd_rst_n |-> sclk);

  assert_phase_min_R3: assert property (@(posedge clk) disable iff (!rst_ni || !run_en)
    (sclk != sclk_prev) |-> (lvl_cnt >= 16'(HALF_CYC)));

  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !(result_valid && frame_error));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    result_valid |=> !result_valid);

  assert_reset_width_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (pd_rst_n && !pd_prev) |-> (low_cnt >= 16'(RESET_LOW_CYC)));

  assert_pin_settle_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!$stable(pin_gain) || !$stable(pin_filter)) |-> settling);
endmodule

bind bridge_adc_reader bar_reader_checks #(
  .HALF_CYC(HALF_CYC), .RESET_LOW_CYC(RESET_LOW_CYC)
) u_checks (
  .clk(clk), .rst_ni(rst_ni), .run_en(run_en), .sclk(sclk), .pd_rst_n(pd_rst_n),
  .pin_gain(pin_gain), .pin_filter(pin_filter), .result_valid(result_valid),
  .frame_error(frame_error), .settling(settle_busy)
);

// File: tb/bridge_adc_reader_test.sv
`timescale 1ns/1ps
module bridge_adc_reader_test;
  localparam int HALF = 10, RLOW = 8, SFAST = 1000, SSLOW = 2500, WAKE = 300;
  localparam int UFAST = 1500, USLOW = 2500;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, cfg_gain_hi = 1'b0, cfg_slow = 1'b0;
  logic signed_out = 1'b0;
  logic [7:0] status_expect = 8'h00, status_mask = 8'h00;
  logic dout_rdy;
  logic sclk, pd_rst_n, pin_gain, pin_filter, result_valid, frame_error, ready_timeout;
  logic [19:0] result;
  logic [7:0]  status_byte;

  always #5 clk = ~clk;

  bridge_adc_reader #(
    .HALF_CYC(HALF), .RESET_LOW_CYC(RLOW), .SETTLE_FAST_CYC(SFAST),
    .SETTLE_SLOW_CYC(SSLOW), .WAKE_CYC(WAKE), .UPD_FAST_CYC(UFAST), .UPD_SLOW_CYC(USLOW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_gain_hi(cfg_gain_hi),
    .cfg_slow(cfg_slow), .signed_out(signed_out), .status_expect(status_expect),
    .status_mask(status_mask), .dout_rdy(dout_rdy), .sclk(sclk), .pd_rst_n(pd_rst_n),
    .pin_gain(pin_gain), .pin_filter(pin_filter), .result(result),
    .status_byte(status_byte), .result_valid(result_valid), .frame_error(frame_error),
    .ready_timeout(ready_timeout)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  logic [27:0] dev_frame = '0;
  int  dev_cnt = 0;
  bit  dev_active = 0;
  logic dev_do = 1'b1;
  int  sclk_falls = 0;
  assign dout_rdy = dev_do;

  always begin
    @(negedge sclk);
    sclk_falls++;
    if (dev_active && dev_cnt < 28) begin
      #20;
      dev_do = dev_frame[27 - dev_cnt];
      dev_cnt++;
    end
  end
  always begin
    @(posedge sclk);
    if (dev_active && dev_cnt == 28) begin
      #30;
      dev_do = 1'b1;
      dev_active = 0;
    end
  end

  // shortest sclk phase seen while enabled
  int run_len = 0, min_phase = 1000000;
  logic sclk_last = 1'b1;
  always @(negedge clk) begin
    if (pd_rst_n && sclk != sclk_last && run_len < min_phase) min_phase = run_len;
    run_len   = (sclk != sclk_last) ? 1 : run_len + 1;
    sclk_last = sclk;
  end

  logic [19:0] last_res = '0;

  // kind: 0 = dropped, 1 = valid, 2 = error
  task automatic run_frame(input logic [19:0] w, input logic [7:0] s, input int kind,
                           input string req);
    int nv = 0, ne = 0, f0;
    logic [19:0] cap = '0;
    logic [19:0] expv;
    repeat (30) @(negedge clk);
    f0 = sclk_falls;
    dev_frame = {w, s};
    dev_cnt = 0;
    dev_active = 1;
    dev_do = 1'b0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (result_valid) begin nv++; cap = result; end
      if (frame_error) ne++;
    end
    expv = signed_out ? (w ^ 20'h80000) : w;
    chk(sclk_falls - f0 == 28, "R2 falls per frame", sclk_falls - f0, 28);
    chk(nv == (kind == 1 ? 1 : 0), {req, " valid count"}, nv, kind == 1);
    chk(ne == (kind == 2 ? 1 : 0), "R6/R7 error count", ne, kind == 2);
    if (kind == 1) begin
      chk(cap == expv, "R4/R5 result value", cap, expv);
      last_res = expv;
    end else begin
      chk(result == last_res, "R6/R7 result held", result, last_res);
    end
    if (kind != 0) chk(status_byte == s, "R4 status byte", status_byte, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lowc;
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // reset state
    chk(sclk == 1'b1, "R1 sclk idle in reset", sclk, 1);
    chk(pd_rst_n == 1'b0, "R8 pd low with run_en low", pd_rst_n, 0);
    chk(!result_valid && !frame_error, "R7 no pulse after reset",
        {result_valid, frame_error}, 0);
    chk(ready_timeout == 1'b0, "R11 no timeout in reset", ready_timeout, 0);

    // R8: brief drop of run_en still gives a full-width reset pulse
    run_en = 1'b1;
    while (!pd_rst_n) @(negedge clk);
    repeat (40) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
    lowc = 0;
    while (!pd_rst_n) begin lowc++; @(negedge clk); end
    chk(lowc >= RLOW, "R8 reset pulse width", lowc, RLOW);

    // R10: wake extends settle to SFAST+WAKE; frame ends ~1095 cycles later -> dropped
    repeat (470) @(negedge clk);
    run_frame(20'h12345, 8'h00, 0, "R10 wake window");
    run_frame(20'h12345, 8'h00, 1, "R10 after wake");

    // R4/R5 sweep across codes and both formats
    begin
      logic [19:0] edges [4] = '{20'h00000, 20'hFFFFF, 20'h80000, 20'h7FFFF};
      for (int i = 0; i < 16; i++) begin
        logic [19:0] w;
        w = (i < 4) ? edges[i] : 20'((i * 32'h2AAAB + i * i * 37) & 32'hFFFFF);
        signed_out = i[0];
        run_frame(w, 8'((i * 29) & 255), 1, "R5 sweep");
      end
    end
    signed_out = 1'b0;

    // R6 masked status compare
    status_expect = 8'hA5;
    status_mask   = 8'hF0;
    run_frame(20'h0ABCD, 8'hA0, 1, "R6 masked match");
    run_frame(20'h11111, 8'hB5, 2, "R6 bit4 mismatch");
    run_frame(20'h22222, 8'h25, 2, "R6 bit7 mismatch");
    run_frame(20'h33333, 8'hAF, 1, "R6 low nibble ignored");
    status_mask = 8'h00;

    // R9 gain change, fast window
    @(negedge clk);
    cfg_gain_hi = 1'b1;
    @(negedge clk);
    chk(pin_gain == 1'b1, "R9 gain pin follows", pin_gain, 1);
    run_frame(20'h44444, 8'h00, 0, "R9 fast window");
    run_frame(20'h55555, 8'h00, 1, "R9 after fast window");

    // R9 filter change, slow window
    cfg_slow = 1'b1;
    @(negedge clk);
    chk(pin_filter == 1'b1, "R9 filter pin follows", pin_filter, 1);
    repeat (1070) @(negedge clk);
    run_frame(20'h66666, 8'h00, 0, "R9 slow window");
    repeat (900) @(negedge clk);
    run_frame(20'h77777, 8'h00, 1, "R9 after slow window");

    // R11 timeout in slow mode (limit 5000), R2 no clocks while ready high
    f0 = sclk_falls;
    repeat (4700) @(negedge clk);
    chk(ready_timeout == 1'b0, "R11 slow below limit", ready_timeout, 0);
    repeat (600) @(negedge clk);
    chk(ready_timeout == 1'b1, "R11 slow past limit", ready_timeout, 1);
    chk(sclk_falls == f0, "R2 no sclk while ready high", sclk_falls - f0, 0);
    chk(sclk == 1'b1, "R1 sclk idle high", sclk, 1);

    // back to fast: settle clears the flag, then fast limit 3000 after settle
    cfg_slow = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready_timeout == 1'b0, "R11 cleared by settle", ready_timeout, 0);
    repeat (1000 + 2700) @(negedge clk);
    chk(ready_timeout == 1'b0, "R11 fast below limit", ready_timeout, 0);
    repeat (600) @(negedge clk);
    chk(ready_timeout == 1'b1, "R11 fast past limit", ready_timeout, 1);
    run_frame(20'h89ABC, 8'h00, 1, "R11 frame after timeout");
    chk(ready_timeout == 1'b0, "R11 cleared by read", ready_timeout, 0);

    chk(min_phase >= HALF, "R3 min sclk phase", min_phase, HALF);

    // R8/R1: power-down holds pins
    run_en = 1'b0;
    repeat (50) @(negedge clk);
    chk(pd_rst_n == 1'b0, "R8 pd held low", pd_rst_n, 0);
    chk(sclk == 1'b1, "R1 sclk high in power-down", sclk, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule